// File: doc/BRIEF.md
# Single Conversion Acquisition Controller

This block drives the four-wire serial port of a delta-sigma converter to get one conversion result on Setup 1 for each start request. A pulse on `start` while the block is idle launches a fixed sequence of frames. First, a configuration read frame (command 0x0B, 24 data bits back). Then a configuration write frame (command 0x03) that returns the same word with the three low bits of its top byte cleared, so the multiple-conversion, loop and read-convert controls are all off. Last, a conversion frame. In that frame the convert command 0x80 is sent, chip select stays low while SDO is polled, and once SDO goes low the block sends eight clocks with SDI low to release the data. It then shifts in 24 bits, MSB first. The result is decoded and presented on registered outputs with a one-cycle `valid` pulse.

The `mode16` input is latched at start and selects how the 24 received bits are read. In 24-bit mode they form the whole result. In 16-bit mode the first two bytes are the result. The trailing byte carries a fixed 0111 tag followed by two channel-indicator bits, an oscillation-detect bit and an overflow bit. If SDO does not fall within `TIMEOUT` cycles, the sequence is abandoned, chip select is released and `timeout` pulses.

The control path is one state machine. Its states are ST_IDLE, ST_RD_CFG, ST_GAP_A, ST_WR_CFG, ST_GAP_B, ST_CONV_CMD, ST_WAIT_SDO, ST_FETCH, ST_FINISH and ST_ABORT. Its transitions are:
- IDLE to RD_CFG on start.
- RD_CFG to GAP_A, WR_CFG to GAP_B, CONV_CMD to WAIT_SDO and FETCH to FINISH, each when its frame's last bit is done.
- GAP_A to WR_CFG and GAP_B to CONV_CMD, after one cycle with chip select high.
- WAIT_SDO to FETCH when SDO is low, or to ABORT when the wait limit expires.
- FINISH and ABORT back to IDLE.

Top module: `acq_ctrl`

## Requirements
- R1: After reset, cs_n=1, sclk=0, sdi=0, busy=0, valid=0, timeout=0, and result, chan_id, osc_flag, ovf_flag and fmt_err are all 0.
- R2: A start pulse while idle raises busy on the next cycle and opens a frame that sends 0x0B MSB first, then clocks 24 more bits in; cs_n is low for exactly that frame.
- R3: The second frame sends 0x03 followed by the word read in R2 with bits 18..16 (the low three bits of its top byte) forced to 0 and all other bits unchanged; cs_n is high for at least one cycle between frames.
- R4: The third frame sends 0x80, keeps cs_n low and waits for sdo to go low however long that takes, including a first conversion that is longer than later ones.
- R5: After sdo falls, 8 clocks are sent with sdi low, then 24 bits are captured MSB first with sdi still low, and cs_n rises.
- R6: With mode16=0 at start, result equals the 24 captured bits, and chan_id, osc_flag, ovf_flag and fmt_err are 0.
- R7: With mode16=1 at start, result is {8'h00, first 16 captured bits}, chan_id = captured bits [3:2], osc_flag = bit [1], ovf_flag = bit [0].
- R8: With mode16=1, fmt_err is 1 exactly when captured bits [7:4] differ from 4'b0111.
- R9: valid is a one-cycle pulse in the cycle cs_n rises at the end of the conversion frame; the result outputs change only in that cycle and hold otherwise.
- R10: If sdo is still high TIMEOUT cycles after ST_WAIT_SDO is entered (DIV_HALF+1+TIMEOUT cycles after the last rising sclk of 0x80), cs_n rises, timeout pulses for one cycle, valid stays 0 and the result outputs keep their values.
- R11: A start pulse while busy is ignored: each accepted start yields exactly one 0x0B, 0x03, 0x80 frame sequence.
- R12: sclk idles low, is high only while cs_n is low, stays high for DIV_HALF cycles per bit, and sdi does not change while sclk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one acquisition |
| mode16 | input | 1 | 1 selects the 16-bit word with status byte; latched at start |
| busy | output | 1 | Sequence in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial data to converter |
| sdo | input | 1 | Serial data / ready flag from converter |
| result | output | 24 | Conversion value |
| chan_id | output | 2 | Channel indicator (16-bit mode) |
| osc_flag | output | 1 | Oscillation-detect flag (16-bit mode) |
| ovf_flag | output | 1 | Overflow flag (16-bit mode) |
| fmt_err | output | 1 | Status tag mismatch (16-bit mode) |
| valid | output | 1 | One-cycle pulse when a new result is presented |
| timeout | output | 1 | One-cycle pulse when the SDO wait is abandoned |

## Verification
The converter model returns distinct configuration words: one with the bits to be cleared set, one all ones, and one with them already clear. Comparing the written-back word against each shows whether the mask hits only bits 18..16. Conversion words include an alternating pattern, a lone LSB and all ones in 24-bit mode, plus 16-bit words with different channel, flag and tag bits. These separate a wrong byte order, a bit slip after the eight flush clocks, and flags taken from the wrong positions. A run where SDO never falls, followed by a normal run, shows that an abort leaves the held result alone and that the block recovers. A second start mid-sequence shows whether requests are ignored while busy.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CFG,
        ST_GAP_A,
        ST_WR_CFG,
        ST_GAP_B,
        ST_CONV_CMD,
        ST_WAIT_SDO,
        ST_FETCH,
        ST_FINISH,
        ST_ABORT
    } acq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } sclk_phase_t;

    localparam logic [7:0] CMD_CFG_READ  = 8'h0B;
    localparam logic [7:0] CMD_CFG_WRITE = 8'h03;
    localparam logic [7:0] CMD_CONVERT   = 8'h80;
    localparam logic [7:0] CFG_TOP_MASK  = 8'hF8;
    localparam logic [3:0] FMT16_TAG     = 4'b0111;

    typedef struct packed {
        logic [23:0] value;
        logic [1:0]  chan;
        logic        osc;
        logic        ovf;
        logic        fmt_bad;
    } acq_result_t;

endpackage

// File: rtl/acq_shift.sv
module acq_shift
    import acq_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int TX_W     = 32,
    parameter int RX_W     = 24,
    parameter int LEN_W    = $clog2(TX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] len,
    input  logic [TX_W-1:0]  tx,
    input  logic             sdo,
    output logic             sclk,
    output logic             sdi,
    output logic             done,
    output logic [RX_W-1:0]  rx
);

    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DW-1:0] D_LAST = DW'(DIV_HALF - 1);

    sclk_phase_t      phase;
    logic [DW-1:0]    dcnt;
    logic [LEN_W-1:0] left;
    logic [TX_W-1:0]  txr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            dcnt  <= '0;
            left  <= '0;
            txr   <= '0;
            rx    <= '0;
            sclk  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase <= PH_LOW;
                        txr   <= tx;
                        left  <= len;
                        dcnt  <= '0;
                    end
                end
                PH_LOW: begin
                    if (dcnt == D_LAST) begin
                        dcnt  <= '0;
                        phase <= PH_HIGH;
                        sclk  <= 1'b1;
                        rx    <= {rx[RX_W-2:0], sdo};
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (dcnt == D_LAST) begin
                        dcnt <= '0;
                        sclk <= 1'b0;
                        txr  <= {txr[TX_W-2:0], 1'b0};
                        left <= left - 1'b1;
                        if (left == LEN_W'(1)) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            phase <= PH_LOW;
                        end
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign sdi = (phase == PH_IDLE) ? 1'b0 : txr[TX_W-1];

    // R12
    shift_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (phase == PH_IDLE));

    // R12
    shift_done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sclk);

endmodule

// File: rtl/acq_wait_timer.sv
module acq_wait_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] C_LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != C_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == C_LAST);

    // R10
    wait_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !run);

endmodule

// File: rtl/acq_decode.sv
module acq_decode
    import acq_pkg::*;
(
    input  logic        mode16,
    input  logic [23:0] raw,
    output acq_result_t res
);

    always_comb begin
        res = '0;
        if (mode16) begin
            res.value   = {8'h00, raw[23:8]};
            res.chan    = raw[3:2];
            res.osc     = raw[1];
            res.ovf     = raw[0];
            res.fmt_bad = (raw[7:4] != FMT16_TAG);
        end else begin
            res.value = raw;
        end
    end

endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int TIMEOUT  = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode16,
    output logic        busy,
    output logic        cs_n,
    output logic        sclk,
    output logic        sdi,
    input  logic        sdo,
    output logic [23:0] result,
    output logic [1:0]  chan_id,
    output logic        osc_flag,
    output logic        ovf_flag,
    output logic        fmt_err,
    output logic        valid,
    output logic        timeout
);

    localparam int FRAME_W = 32;
    localparam int DATA_W  = 24;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(FRAME_W);
    localparam logic [LEN_W-1:0] LEN_CMD  = LEN_W'(8);

    acq_state_t          state, nxt;
    logic                sh_go, sh_done;
    logic [LEN_W-1:0]    sh_len;
    logic [FRAME_W-1:0]  sh_tx;
    logic [DATA_W-1:0]   sh_rx;
    logic [DATA_W-1:0]   cfg_q;
    logic                mode_q;
    logic                wait_run, wait_exp;
    acq_result_t         dec;

    acq_shift #(
        .DIV_HALF (DIV_HALF),
        .TX_W     (FRAME_W),
        .RX_W     (DATA_W),
        .LEN_W    (LEN_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (sh_go),
        .len   (sh_len),
        .tx    (sh_tx),
        .sdo   (sdo),
        .sclk  (sclk),
        .sdi   (sdi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    acq_wait_timer #(
        .LIMIT (TIMEOUT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (wait_exp)
    );

    acq_decode u_decode (
        .mode16 (mode_q),
        .raw    (sh_rx),
        .res    (dec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_RD_CFG;
            ST_RD_CFG:   if (sh_done) nxt = ST_GAP_A;
            ST_GAP_A:    nxt = ST_WR_CFG;
            ST_WR_CFG:   if (sh_done) nxt = ST_GAP_B;
            ST_GAP_B:    nxt = ST_CONV_CMD;
            ST_CONV_CMD: if (sh_done) nxt = ST_WAIT_SDO;
            ST_WAIT_SDO: begin
                if (!sdo)          nxt = ST_FETCH;
                else if (wait_exp) nxt = ST_ABORT;
            end
            ST_FETCH:    if (sh_done) nxt = ST_FINISH;
            ST_FINISH:   nxt = ST_IDLE;
            ST_ABORT:    nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // frame launch and contents
    always_comb begin
        sh_go  = (nxt != state) &&
                 (nxt inside {ST_RD_CFG, ST_WR_CFG, ST_CONV_CMD, ST_FETCH});
        sh_len = LEN_FULL;
        sh_tx  = '0;
        unique case (nxt)
            ST_RD_CFG:   sh_tx = {CMD_CFG_READ, 24'h000000};
            ST_WR_CFG:   sh_tx = {CMD_CFG_WRITE, cfg_q[23:16] & CFG_TOP_MASK, cfg_q[15:0]};
            ST_CONV_CMD: begin
                sh_tx  = {CMD_CONVERT, 24'h000000};
                sh_len = LEN_CMD;
            end
            default:     sh_tx = '0;
        endcase
    end

    assign cs_n     = !(state inside {ST_RD_CFG, ST_WR_CFG, ST_CONV_CMD, ST_WAIT_SDO, ST_FETCH});
    assign busy     = (state != ST_IDLE);
    assign wait_run = (state == ST_WAIT_SDO);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            mode_q   <= 1'b0;
            result   <= '0;
            chan_id  <= '0;
            osc_flag <= 1'b0;
            ovf_flag <= 1'b0;
            fmt_err  <= 1'b0;
            valid    <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            valid   <= 1'b0;
            timeout <= 1'b0;
            if (state == ST_IDLE && start) begin
                mode_q <= mode16;
            end
            if (state == ST_RD_CFG && sh_done) begin
                cfg_q <= sh_rx;
            end
            if (state == ST_FETCH && sh_done) begin
                result   <= dec.value;
                chan_id  <= dec.chan;
                osc_flag <= dec.osc;
                ovf_flag <= dec.ovf;
                fmt_err  <= dec.fmt_bad;
                valid    <= 1'b1;
            end
            if (state == ST_WAIT_SDO && sdo && wait_exp) begin
                timeout <= 1'b1;
            end
        end
    end

    // R12
    sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R5
    flush_sdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> !sdi);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable({result, chan_id, osc_flag, ovf_flag, fmt_err}));

    // R10
    timeout_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!valid && cs_n));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (state != ST_FINISH) && (state != ST_ABORT)) |=> busy);

endmodule

// File: tb/tb_acq_ctrl.sv
module tb_acq_ctrl;

    localparam int DIV_HALF = 2;
    localparam int TMO      = 300;
    localparam int CONV_DLY = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode16 = 1'b0;
    logic        sdo = 1'b1;
    logic        busy, cs_n, sclk, sdi;
    logic [23:0] result;
    logic [1:0]  chan_id;
    logic        osc_flag, ovf_flag, fmt_err, valid, timeout;

    always #2 clk = ~clk;

    acq_ctrl #(.DIV_HALF(DIV_HALF), .TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode16(mode16),
        .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .result(result), .chan_id(chan_id), .osc_flag(osc_flag),
        .ovf_flag(ovf_flag), .fmt_err(fmt_err), .valid(valid), .timeout(timeout)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // converter model state
    int          nbit = 0;
    logic [7:0]  cmd = 8'h00;
    logic [31:0] inbits = '0;
    bit          p_cs = 1'b1, p_sclk = 1'b0, p_sdi = 1'b0;
    int          hi_len = 0;
    int          conv_cnt = 0;
    int          cyc = 0;
    int          rise8_cyc = 0;
    logic [23:0] m_cfg = '0, m_conv = '0;
    bit          m_mode16 = 1'b0, m_hang = 1'b0, m_first = 1'b1;
    logic [7:0]  cmds[$];
    logic [23:0] wr_seen[$];
    int          flush_bad = 0;
    int          n_valid = 0, n_tmo = 0;

    // expected outputs
    logic [23:0] e_res = '0;
    logic [1:0]  e_ch = '0;
    bit          e_osc = 0, e_ovf = 0, e_fmt = 0, e_valid = 0, e_tmo = 0;

    always @(negedge clk) begin
        cyc++;
        e_valid = 1'b0;
        e_tmo   = 1'b0;
        if (!cs_n && p_cs) begin
            nbit = 0; inbits = '0; cmd = 8'h00;
        end
        if (!cs_n && sclk && !p_sclk) begin
            inbits = {inbits[30:0], sdi};
            nbit++;
            hi_len = 0;
            if (nbit == 8) begin
                cmd = inbits[7:0];
                cmds.push_back(cmd);
                if (cmd == 8'h80) begin
                    rise8_cyc = cyc;
                    sdo = 1'b1;
                    if (m_hang) conv_cnt = 0;
                    else begin
                        conv_cnt = m_first ? CONV_DLY + 7 : CONV_DLY;
                        m_first = 1'b0;
                    end
                end
            end
            if (cmd == 8'h80 && nbit > 8 && sdi) flush_bad++;
            if (cmd == 8'h03 && nbit == 32) wr_seen.push_back(inbits[23:0]);
        end
        if (sclk) hi_len++;
        if (!cs_n && !sclk && p_sclk) begin
            chk(hi_len == DIV_HALF, "R12 sclk high length", hi_len, DIV_HALF);
            if (cmd == 8'h0B && nbit >= 8 && nbit < 32) sdo = m_cfg[31-nbit];
            if (cmd == 8'h80 && nbit >= 16 && nbit < 40) sdo = m_conv[39-nbit];
        end
        if (cs_n && !p_cs) begin
            if (cmd == 8'h80 && nbit == 40) begin
                e_valid = 1'b1;
                if (m_mode16) begin
                    e_res = {8'h00, m_conv[23:8]};
                    e_ch  = m_conv[3:2];
                    e_osc = m_conv[1];
                    e_ovf = m_conv[0];
                    e_fmt = (m_conv[7:4] != 4'b0111);
                end else begin
                    e_res = m_conv; e_ch = 2'b00; e_osc = 0; e_ovf = 0; e_fmt = 0;
                end
            end else if (cmd == 8'h80 && nbit == 8) begin
                e_tmo = 1'b1;
                chk(cyc - rise8_cyc == DIV_HALF + 1 + TMO, "R10 wait length", cyc - rise8_cyc, DIV_HALF + 1 + TMO);
            end
            sdo = 1'b1;
            conv_cnt = 0;
        end
        if (conv_cnt > 0) begin
            conv_cnt--;
            if (conv_cnt == 0) sdo = 1'b0;
        end
        if (valid) n_valid++;
        if (timeout) n_tmo++;
        // R6/R7/R8/R9/R10 per-cycle output comparison
        chk({valid, timeout, result, chan_id, osc_flag, ovf_flag, fmt_err} ===
            {e_valid, e_tmo, e_res, e_ch, e_osc, e_ovf, e_fmt},
            "R6/R7/R8/R9/R10 outputs",
            {1'b0, valid, timeout, result, chan_id, osc_flag, ovf_flag, fmt_err},
            {1'b0, e_valid, e_tmo, e_res, e_ch, e_osc, e_ovf, e_fmt});
        if (sclk && cs_n) chk(1'b0, "R12 sclk while deselected", 1, 0);
        if (sclk && p_sclk && (sdi != p_sdi)) chk(1'b0, "R12 sdi moved while sclk high", sdi, p_sdi);
        p_cs = cs_n; p_sclk = sclk; p_sdi = sdi;
    end

    task automatic run_op(input bit md, input logic [23:0] cfg, input logic [23:0] conv, input bit hang);
        cmds.delete();
        wr_seen.delete();
        flush_bad = 0; n_valid = 0; n_tmo = 0;
        m_mode16 = md; m_cfg = cfg; m_conv = conv; m_hang = hang;
        @(negedge clk); mode16 = md; start = 1'b1;
        @(negedge clk); start = 1'b0; mode16 = ~md;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        repeat (20) @(negedge clk);
        start = 1'b1;                       // R11 request while busy
        @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(cmds.size() == 3, "R11 frames per start", cmds.size(), 3);
        if (cmds.size() == 3) begin
            chk(cmds[0] == 8'h0B, "R2 read command", cmds[0], 8'h0B);
            chk(cmds[1] == 8'h03, "R3 write command", cmds[1], 8'h03);
            chk(cmds[2] == 8'h80, "R4 convert command", cmds[2], 8'h80);
        end
        chk(wr_seen.size() == 1, "R3 write frame count", wr_seen.size(), 1);
        if (wr_seen.size() == 1)
            chk(wr_seen[0] == {cfg[23:16] & 8'hF8, cfg[15:0]}, "R3 masked config",
                wr_seen[0], {cfg[23:16] & 8'hF8, cfg[15:0]});
        chk(flush_bad == 0, "R5 sdi low after ready", flush_bad, 0);
        chk(n_valid == (hang ? 0 : 1), "R9 valid count", n_valid, hang ? 0 : 1);
        chk(n_tmo == (hang ? 1 : 0), "R10 timeout count", n_tmo, hang ? 1 : 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && sdi == 1'b0, "R1 port idle", {cs_n, sclk, sdi}, 3'b100);
        chk(busy == 1'b0 && valid == 1'b0 && timeout == 1'b0, "R1 status idle", {busy, valid, timeout}, 0);
        chk(result == 24'h0 && fmt_err == 1'b0, "R1 result cleared", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 24'h07A5C3, 24'hA5C33C, 1'b0);   // R4 first (longer) conversion, R6
        run_op(1'b0, 24'hFFFFFF, 24'h000001, 1'b0);   // R6 lone LSB
        run_op(1'b1, 24'h001234, 24'h12347B, 1'b0);   // R7
        run_op(1'b1, 24'h5A0F0F, 24'hBEEF74, 1'b0);   // R7 other channel
        run_op(1'b1, 24'h030000, 24'h00015B, 1'b0);   // R8 bad tag
        run_op(1'b1, 24'h000000, 24'h123456, 1'b1);   // R10 sdo never falls
        run_op(1'b0, 24'h000000, 24'hFFFFFF, 1'b0);   // recovery after abort
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000 && !finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule